// File: doc/BRIEF.md
# Interrupt Controller Setup and Command Register Port

This block is the byte-wide register front end of an eight-line priority interrupt controller. It sits between a processor's two-location register window and the controller's priority logic. It holds the line mask, the in-service vector, the rotating priority base, the operating-mode flags and the vector base. It turns bytes written at the two locations into setup steps, mode changes and end-of-interrupt commands. It also exports that state as plain outputs so that the neighbouring request-capture and vectoring logic can use it.

A write to location 0 does one of three things, depending on two of its bits. It can open a setup sequence, change a mode, or issue a priority command. Writes to location 1 either load the mask or feed the next setup word, depending on where the setup sequencer stands. Reads return the mask, the in-service vector or the live request vector. After a poll has been armed, one read instead returns the winning line and acknowledges it. An external acknowledge with a line index marks a line as taken. The priority search is internal. Requests are captured elsewhere and arrive here as a level vector.

The register strobes are plain single-cycle controls. This port carries no streamed data, so there is no valid/ready handshake and no back-pressure. A write or read takes effect at the clock edge where its strobe is high. Read data is combinational while `rd_en` is high.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset the mask, in-service vector, priority base, vector base and every mode flag are zero. No poll is armed, read-select is 0 and the setup sequencer is idle, so a location-1 write loads the mask.
- R2: A location-0 write with bit 4 set clears the mask, in-service vector, priority base, vector base, all mode flags, poll and read-select. It stores bit 1 as single mode and bit 0 as "fourth word needed", and moves the sequencer to the base step.
- R3: In the base step, a location-1 write stores bits 7:3 as the vector base. The sequencer then goes to the mode step if single mode and fourth word are both set, to idle if single mode is set without the fourth word, and to the cascade step otherwise.
- R4: In the cascade step, a location-1 write changes no register and goes to the mode step if the fourth word is needed, else to idle. In the mode step, bit 4 sets the nested-mode flag and bit 1 sets the auto-EOI flag, and the sequencer returns to idle.
- R5: When the sequencer is idle, a location-1 write loads the mask. A non-poll read at location 1 returns the mask. The mask never changes without a write.
- R6: A location-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms a poll. Bit 1 lets bit 0 set read-select. Bit 6 lets bit 5 set the special-mask flag. A non-poll read at location 0 returns the in-service vector when read-select is 1 and the request vector when it is 0.
- R7: A location-0 write with bits 4 and 3 clear carries a command in bits 7:5. Command 4 sets the rotate-on-auto-EOI flag. Command 0 clears it. Command 2 changes nothing.
- R8: Priority rank k belongs to line (base + k) mod 8, and a lower rank means higher priority. Command 1 clears the highest-priority in-service bit. Command 5 does the same and also sets the base to that line + 1 (mod 8). With no bit in service, neither command changes anything.
- R9: Command 3 clears the in-service bit named by bits 2:0. Command 6 sets the base to bits 2:0 + 1 (mod 8). Command 7 does both for the named line.
- R10: An acknowledge of line n sets in-service bit n when auto-EOI is off. With auto-EOI on, it leaves the in-service vector unchanged and, if rotate-on-auto-EOI is set, sets the base to n + 1 (mod 8).
- R11: The poll winner is the highest-priority line of request AND NOT mask. It wins only if its rank is strictly lower than the rank of the highest in-service bit; when special mask is set, masked lines are left out of that in-service comparison. A read with poll armed returns 0x80 OR the winner and acknowledges it as in R10, whatever the location. If there is no winner it returns 0x00. Either way the poll is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | Register location select (0 or 1) |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write byte |
| req_vec | input | LINES | Live request vector from the capture logic |
| ack_valid | input | 1 | Acknowledge of a line |
| ack_line | input | LW | Index of the acknowledged line |
| rd_data | output | 8 | Read byte, valid while rd_en is high |
| irq_mask | output | LINES | Line mask, 1 = masked |
| in_service | output | LINES | In-service vector |
| prio_base | output | LW | Line holding rank 0 |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_on_aeoi | output | 1 | Rotate base on automatic end-of-interrupt |
| nested_mode | output | 1 | Special fully nested mode flag |
| special_mask | output | 1 | Special-mask mode flag |
| single_mode | output | 1 | Single-controller setup flag |
| vec_base | output | 8-LW | Vector base bits |

## Verification
The assertions assume that at most one of write, read and acknowledge is active in any cycle, and a property states that assumption. Same-cycle collisions between commands and acknowledges are therefore left undefined. The stimulus drives every access as a single-cycle strobe with idle cycles in between and never overlaps two of them. The request vector changes only between accesses.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  // Setup sequencer position
  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } init_step_e;

  // Priority command field of a location-0 write
  typedef enum logic [2:0] {
    OP_ROT_CLR = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_SET = 3'd4,
    OP_REOI    = 3'd5,
    OP_SETPRI  = 3'd6,
    OP_RSEOI   = 3'd7
  } prio_op_e;

  // Classification of a location-0 write
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_INIT = 2'd1,
    WK_MODE = 2'd2,
    WK_OP   = 2'd3
  } wr_kind_e;

endpackage

// File: rtl/pic_prio_search.sv
module pic_prio_search #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec,
  input  logic [LW-1:0]    base,
  output logic             hit,
  output logic [LW-1:0]    line
);

  // Per-rank candidate lines; rank k maps to line base+k (wrapping)
  logic [LW-1:0]    cand_line [LINES];
  logic [LINES-1:0] cand_set;

  for (genvar k = 0; k < LINES; k++) begin : g_rank
    assign cand_line[k] = base + LW'(k);
    assign cand_set[k]  = vec[cand_line[k]];
  end

  always_comb begin
    hit  = 1'b0;
    line = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (cand_set[k]) begin
        hit  = 1'b1;
        line = cand_line[k];
      end
    end
  end

  // R8
  always_comb begin
    if (hit) begin
      hit_line_set_chk: assert (vec[line]);
    end
  end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       data_wr,
  input  logic       need4,
  input  logic       single,
  output init_step_e step
);

  init_step_e step_nx;

  always_comb begin
    step_nx = step;
    if (start) begin
      step_nx = STEP_BASE;
    end else if (data_wr) begin
      unique case (step)
        STEP_RUN:  step_nx = STEP_RUN;
        STEP_BASE: step_nx = single ? (need4 ? STEP_MODE : STEP_RUN) : STEP_CASC;
        STEP_CASC: step_nx = need4 ? STEP_MODE : STEP_RUN;
        STEP_MODE: step_nx = STEP_RUN;
        default:   step_nx = STEP_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= STEP_RUN;
    else        step <= step_nx;
  end

  // R3
  base_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_BASE && data_wr && !start && !single) |=> step == STEP_CASC);

  // R4
  casc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_CASC && data_wr && !start && !need4) |=> step == STEP_RUN);

  // R4
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_MODE && data_wr && !start) |=> step == STEP_RUN);

  // R2
  start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> step == STEP_BASE);

endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cmd_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW   = $clog2(LINES),
  localparam int VB_W = 8 - LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wr_data,
  input  logic [LINES-1:0] req_vec,
  input  logic             ack_valid,
  input  logic [LW-1:0]    ack_line,
  output logic [7:0]       rd_data,
  output logic [LINES-1:0] irq_mask,
  output logic [LINES-1:0] in_service,
  output logic [LW-1:0]    prio_base,
  output logic             auto_eoi,
  output logic             rot_on_aeoi,
  output logic             nested_mode,
  output logic             special_mask,
  output logic             single_mode,
  output logic [VB_W-1:0]  vec_base
);

  logic need4;
  logic poll_armed;
  logic rd_sel;

  // Write decode
  wr_kind_e  wkind;
  prio_op_e  op;
  logic      data_wr;
  logic [LW-1:0] sel_line;

  always_comb begin
    wkind = WK_NONE;
    if (wr_en && !reg_addr) begin
      if (wr_data[4])      wkind = WK_INIT;
      else if (wr_data[3]) wkind = WK_MODE;
      else                 wkind = WK_OP;
    end
  end

  assign op       = prio_op_e'(wr_data[7:5]);
  assign data_wr  = wr_en && reg_addr;
  assign sel_line = wr_data[LW-1:0];

  // Setup sequencer
  init_step_e step;

  pic_init_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wkind == WK_INIT),
    .data_wr (data_wr),
    .need4   (need4),
    .single  (single_mode),
    .step    (step)
  );

  // Priority searches
  logic [LINES-1:0] req_eff;
  logic [LINES-1:0] isr_cmp;
  logic             req_hit, cur_hit, eoi_hit;
  logic [LW-1:0]    req_line, cur_line, eoi_line;
  logic [LW-1:0]    req_rank, cur_rank;
  logic             win;

  assign req_eff = req_vec & ~irq_mask;
  assign isr_cmp = special_mask ? (in_service & ~irq_mask) : in_service;

  pic_prio_search #(.LINES(LINES)) u_req (
    .vec (req_eff), .base (prio_base), .hit (req_hit), .line (req_line)
  );

  pic_prio_search #(.LINES(LINES)) u_cur (
    .vec (isr_cmp), .base (prio_base), .hit (cur_hit), .line (cur_line)
  );

  pic_prio_search #(.LINES(LINES)) u_eoi (
    .vec (in_service), .base (prio_base), .hit (eoi_hit), .line (eoi_line)
  );

  assign req_rank = req_line - prio_base;
  assign cur_rank = cur_line - prio_base;
  assign win      = req_hit && (!cur_hit || (req_rank < cur_rank));

  // Acknowledge path (external or by poll read)
  logic          poll_rd;
  logic          take;
  logic [LW-1:0] take_line;

  assign poll_rd   = rd_en && poll_armed;
  assign take      = ack_valid || (poll_rd && win);
  assign take_line = ack_valid ? ack_line : req_line;

  // State registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_mask     <= '0;
      in_service   <= '0;
      prio_base    <= '0;
      auto_eoi     <= 1'b0;
      rot_on_aeoi  <= 1'b0;
      nested_mode  <= 1'b0;
      special_mask <= 1'b0;
      single_mode  <= 1'b0;
      need4        <= 1'b0;
      poll_armed   <= 1'b0;
      rd_sel       <= 1'b0;
      vec_base     <= '0;
    end else begin
      unique case (wkind)
        WK_INIT: begin
          irq_mask     <= '0;
          in_service   <= '0;
          prio_base    <= '0;
          auto_eoi     <= 1'b0;
          rot_on_aeoi  <= 1'b0;
          nested_mode  <= 1'b0;
          special_mask <= 1'b0;
          poll_armed   <= 1'b0;
          rd_sel       <= 1'b0;
          vec_base     <= '0;
          need4        <= wr_data[0];
          single_mode  <= wr_data[1];
        end
        WK_MODE: begin
          if (wr_data[2]) poll_armed   <= 1'b1;
          if (wr_data[1]) rd_sel       <= wr_data[0];
          if (wr_data[6]) special_mask <= wr_data[5];
        end
        WK_OP: begin
          unique case (op)
            OP_ROT_CLR: rot_on_aeoi <= 1'b0;
            OP_ROT_SET: rot_on_aeoi <= 1'b1;
            OP_EOI, OP_REOI: begin
              if (eoi_hit) begin
                in_service[eoi_line] <= 1'b0;
                if (op == OP_REOI) prio_base <= eoi_line + LW'(1);
              end
            end
            OP_SEOI:   in_service[sel_line] <= 1'b0;
            OP_SETPRI: prio_base <= sel_line + LW'(1);
            OP_RSEOI: begin
              in_service[sel_line] <= 1'b0;
              prio_base            <= sel_line + LW'(1);
            end
            default: ;
          endcase
        end
        default: begin
          if (data_wr) begin
            unique case (step)
              STEP_RUN:  irq_mask <= wr_data[LINES-1:0];
              STEP_BASE: vec_base <= wr_data[7:LW];
              STEP_MODE: begin
                nested_mode <= wr_data[4];
                auto_eoi    <= wr_data[1];
              end
              default: ;
            endcase
          end
        end
      endcase

      if (take) begin
        if (auto_eoi) begin
          if (rot_on_aeoi) prio_base <= take_line + LW'(1);
        end else begin
          in_service[take_line] <= 1'b1;
        end
      end

      if (poll_rd) poll_armed <= 1'b0;
    end
  end

  // Read data
  always_comb begin
    if (poll_rd)       rd_data = win ? (8'h80 | 8'(req_line)) : 8'h00;
    else if (reg_addr) rd_data = 8'(irq_mask);
    else if (rd_sel)   rd_data = 8'(in_service);
    else               rd_data = 8'(req_vec);
  end

  // Input contract: one access kind per cycle
  excl_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_valid && (wr_en || rd_en)) && !(wr_en && rd_en));

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wkind == WK_INIT) |=> (irq_mask == '0 && in_service == '0 && prio_base == '0));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq_mask));

  // R10
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !auto_eoi) |=> in_service[$past(ack_line)]);

  // R10
  aeoi_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && auto_eoi) |=> $stable(in_service));

  // R11
  poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |=> !poll_armed);

  // R11
  poll_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !req_hit) |-> rd_data == 8'h00);

endmodule

// File: tb/pic_cmd_port_bench.sv
module pic_cmd_port_bench;

  localparam int LINES = 8;
  localparam int LW    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_addr = 1'b0;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [7:0]       wr_data = 8'h00;
  logic [LINES-1:0] req_vec = '0;
  logic             ack_valid = 1'b0;
  logic [LW-1:0]    ack_line = '0;
  logic [7:0]       rd_data;
  logic [LINES-1:0] irq_mask, in_service;
  logic [LW-1:0]    prio_base;
  logic             auto_eoi, rot_on_aeoi, nested_mode, special_mask, single_mode;
  logic [4:0]       vec_base;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  pic_cmd_port #(.LINES(LINES)) u_pic_cmd_port (
    .clk, .rst_n, .reg_addr, .wr_en, .rd_en, .wr_data, .req_vec,
    .ack_valid, .ack_line, .rd_data, .irq_mask, .in_service, .prio_base,
    .auto_eoi, .rot_on_aeoi, .nested_mode, .special_mask, .single_mode, .vec_base
  );

  always #10 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // Driver: pushes the expected read byte into the scoreboard
  task automatic rd(logic a, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic ack(logic [LW-1:0] l);
    @(posedge clk); #1;
    ack_line = l; ack_valid = 1'b1;
    @(posedge clk); #1;
    ack_valid = 1'b0;
  endtask

  // Monitor: compares read data mid-cycle
  always @(negedge clk) begin
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expected item, actual %0h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    req_vec = 8'h5A;
    @(posedge clk); #1;

    // R1 reset state
    check("R1 mask", irq_mask, 0);
    check("R1 in_service", in_service, 0);
    check("R1 base", prio_base, 0);
    check("R1 flags", {auto_eoi, rot_on_aeoi, nested_mode, special_mask, single_mode}, 0);
    check("R1 vec_base", vec_base, 0);
    rd(1'b0, 8'h5A, "R1 read req");
    rd(1'b1, 8'h00, "R1 read mask");

    // R5 mask load while idle
    wr(1'b1, 8'hF0);
    check("R5 mask load", irq_mask, 8'hF0);
    rd(1'b1, 8'hF0, "R5 mask read");

    // R2/R3/R4 single mode with fourth word
    wr(1'b0, 8'h13);
    check("R2 mask cleared", irq_mask, 0);
    check("R2 single", single_mode, 1);
    wr(1'b1, 8'hA8);
    check("R3 vec_base", vec_base, 5'h15);
    wr(1'b1, 8'h12);
    check("R4 nested", nested_mode, 1);
    check("R4 auto_eoi", auto_eoi, 1);
    wr(1'b1, 8'h3C);
    check("R4 back to idle", irq_mask, 8'h3C);

    // R2/R4 cascade without fourth word
    wr(1'b0, 8'h10);
    check("R2 flags cleared", {auto_eoi, nested_mode, single_mode}, 0);
    check("R2 vec_base cleared", vec_base, 0);
    wr(1'b1, 8'h40);
    check("R3 vec_base casc", vec_base, 5'h08);
    wr(1'b1, 8'hFF);
    check("R4 casc no change mask", irq_mask, 0);
    check("R4 casc no change base", vec_base, 5'h08);
    wr(1'b1, 8'h81);
    check("R4 casc to idle", irq_mask, 8'h81);

    // R4 cascade with fourth word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h02);
    check("R4 aeoi via casc", auto_eoi, 1);
    check("R4 nested off", nested_mode, 0);
    wr(1'b1, 8'h00);

    // R3 single without fourth word
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h08);
    check("R3 vec_base single", vec_base, 5'h01);
    wr(1'b1, 8'h55);
    check("R3 single to idle", irq_mask, 8'h55);
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h00);
    check("R2 aeoi cleared", auto_eoi, 0);

    // R10 acknowledge without auto-EOI
    ack(3'd3);
    check("R10 ack 3", in_service, 8'h08);
    ack(3'd6);
    check("R10 ack 6", in_service, 8'h48);

    // R6 read-select
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h48, "R6 read isr");

    // R8 non-specific EOI
    wr(1'b0, 8'h20);
    check("R8 eoi clears 3", in_service, 8'h40);
    wr(1'b0, 8'hA0);
    check("R8 reoi clears 6", in_service, 8'h00);
    check("R8 reoi base", prio_base, 7);
    wr(1'b0, 8'h20);
    check("R8 eoi empty", {in_service, 5'b0, prio_base}, 7);

    // R9 specific commands
    wr(1'b0, 8'hC2);
    check("R9 set base", prio_base, 3);
    ack(3'd1); ack(3'd5);
    wr(1'b0, 8'h65);
    check("R9 seoi 5", in_service, 8'h02);
    wr(1'b0, 8'hE1);
    check("R9 rseoi isr", in_service, 8'h00);
    check("R9 rseoi base", prio_base, 2);

    // R8 rotated priority
    ack(3'd1); ack(3'd4);
    wr(1'b0, 8'h20);
    check("R8 rotated eoi", in_service, 8'h02);
    wr(1'b0, 8'h20);
    check("R8 last eoi", in_service, 8'h00);

    // R7 rotate flag and no-op
    wr(1'b0, 8'h80);
    check("R7 rot set", rot_on_aeoi, 1);
    wr(1'b0, 8'h40);
    check("R7 nop rot", rot_on_aeoi, 1);
    check("R7 nop base", prio_base, 2);
    check("R7 nop isr", in_service, 0);
    rd(1'b0, 8'h00, "R7 nop read isr");
    wr(1'b0, 8'h00);
    check("R7 rot clr", rot_on_aeoi, 0);

    // R10 auto-EOI
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h80);
    ack(3'd5);
    check("R10 aeoi isr", in_service, 0);
    check("R10 aeoi rotate", prio_base, 6);
    wr(1'b0, 8'h00);
    ack(3'd2);
    check("R10 aeoi no rotate", prio_base, 6);

    // R11 poll
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h00);
    req_vec = 8'h28;
    rd(1'b0, 8'h28, "R2 read-select cleared");
    wr(1'b0, 8'h0C);
    rd(1'b1, 8'h83, "R11 poll win 3");
    check("R11 poll ack", in_service, 8'h08);
    rd(1'b1, 8'h00, "R11 poll disarmed");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R11 equal rank loses");
    rd(1'b0, 8'h28, "R11 disarmed after empty");
    wr(1'b1, 8'h08);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R11 blocked by isr");
    wr(1'b0, 8'h68);
    check("R6 special mask", special_mask, 1);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h85, "R11 special mask win");
    check("R11 ack 5", in_service, 8'h28);
    req_vec = 8'h00;
    wr(1'b0, 8'h0C);
    rd(1'b1, 8'h00, "R11 no request");
    wr(1'b0, 8'h48);
    check("R6 special clear", special_mask, 0);

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule